// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block sits beside the processor core of a small microcontroller and turns a software power-mode selection into six enable lines: one for the CPU, one each for the main clock, the sub-main (peripheral) clock and the auxiliary clock, one for the DC generator of the digitally controlled oscillator, and one for the crystal oscillator. Six modes are defined. The active mode keeps everything running. Five low-power modes, LP0 to LP4, switch off progressively more of the clock tree. LP4 stops every clock and both oscillator parts.

Software selects a mode by presenting a 3-bit code together with a write strobe. A pending interrupt brings the system back to active mode at once, and the block remembers the mode it left. When the handler signals its return with a one-cycle strobe, the remembered mode is put back. A handler may write a new code while it runs. That code then becomes the mode that is resumed, which lets a handler keep the system awake after it returns. A one-cycle flag marks every wake-up that actually left a low-power mode.

Top module: `pmode_gate_ctrl`

## Requirements
- R1: While reset is asserted, and until the first accepted event after it, the block is in active mode with all six enables high and `wake_done_o` low. Reset also clears the remembered mode to active.
- R2: Code 0 selects active mode, in which all six enables are 1.
- R3: Code 1 (LP0) turns off CPU and main clock. Sub-main clock, auxiliary clock, DC generator and crystal stay on.
- R4: Code 2 (LP1) gives the same gating as LP0, except that the DC generator enable equals the parameter `DCO_MAIN_SRC` (default 1, so it stays on).
- R5: Code 3 (LP2) turns off CPU, main clock and sub-main clock. Auxiliary clock, DC generator and crystal stay on.
- R6: Code 4 (LP3) gives the same gating as LP2, except that the DC generator is off.
- R7: Code 5 (LP4) drives all six enables low.
- R8: Codes 6 and 7 are undefined and select active mode.
- R9: A mode write that is not inside interrupt service appears on the enables in the cycle after the one in which the strobe is high, and never in the same cycle.
- R10: If an interrupt is pending outside service while a low-power mode is in force, the next cycle is active mode, service begins, and `wake_done_o` is high for exactly that one cycle.
- R11: A return strobe during service restores the remembered mode in the next cycle and ends service. If a write comes in the same cycle, the written code is restored instead.
- R12: During service the enables stay in active mode. Pending interrupts start no new wake. A write during service only replaces the remembered mode.
- R13: A return strobe outside service has no effect.
- R14: If an interrupt is pending while active mode is in force outside service, service begins with active mode remembered, and `wake_done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_code_i | input | 3 | Requested mode code (0 active, 1..5 LP0..LP4) |
| mode_wr_i | input | 1 | Write strobe for `mode_code_i` |
| irq_pend_i | input | 1 | Interrupt pending |
| reti_i | input | 1 | Return-from-handler strobe |
| cpu_en_o | output | 1 | CPU enable |
| mclk_en_o | output | 1 | Main clock enable |
| smclk_en_o | output | 1 | Sub-main clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| dcgen_en_o | output | 1 | Oscillator DC generator enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| wake_done_o | output | 1 | One-cycle pulse when a wake-up leaves a low-power mode |

## Verification
The bench targets four situations. The first is a write and a return strobe in the same cycle during service: a design that gives the stored mode priority would resume the stale mode. The second is an interrupt raised while already active: a design that flags every service entry would pulse `wake_done_o` for it. The third is a return strobe outside service: a design that does not qualify the strobe would fall back into the reset-cleared remembered mode. The fourth is the undefined codes 6 and 7, which a design with a loose decode would map onto a gating pattern. Random mixes of writes, interrupts and returns then cover the remaining orderings against a reference model in the bench.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

  localparam int unsigned MODE_W    = 3;
  localparam int unsigned NUM_MODES = 6;
  localparam logic [MODE_W-1:0] LAST_CODE = MODE_W'(NUM_MODES - 1);

  typedef enum logic [MODE_W-1:0] {
    PM_ACTIVE = 3'd0,
    PM_LP0    = 3'd1,
    PM_LP1    = 3'd2,
    PM_LP2    = 3'd3,
    PM_LP3    = 3'd4,
    PM_LP4    = 3'd5
  } pmode_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic dcgen;
    logic xtal;
  } gate_t;

endpackage

// File: rtl/pmg_rst_sync.sv
module pmg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/pmg_mode_decode.sv
module pmg_mode_decode
  import pmg_pkg::*;
(
  input  logic [MODE_W-1:0] code_i,
  output pmode_e            mode_o
);

  // Undefined codes fall back to full activity.
  always_comb begin
    if (code_i <= LAST_CODE) mode_o = pmode_e'(code_i);
    else                     mode_o = PM_ACTIVE;
  end

endmodule

// File: rtl/pmg_gate_map.sv
module pmg_gate_map
  import pmg_pkg::*;
#(
  parameter bit DCO_MAIN_SRC = 1'b1
) (
  input  pmode_e mode_i,
  output gate_t  gate_o
);

  logic lp1_dcgen;

  // LP1 keeps the DC generator alive only if the DCO feeds the active-mode clock.
  generate
    if (DCO_MAIN_SRC) begin : g_dco_main
      assign lp1_dcgen = 1'b1;
    end else begin : g_dco_other
      assign lp1_dcgen = 1'b0;
    end
  endgenerate

  always_comb begin
    gate_o = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1, aclk: 1'b1, dcgen: 1'b1, xtal: 1'b1};
    unique case (mode_i)
      PM_ACTIVE: ;
      PM_LP0: begin
        gate_o.cpu  = 1'b0;
        gate_o.mclk = 1'b0;
      end
      PM_LP1: begin
        gate_o.cpu   = 1'b0;
        gate_o.mclk  = 1'b0;
        gate_o.dcgen = lp1_dcgen;
      end
      PM_LP2: begin
        gate_o.cpu   = 1'b0;
        gate_o.mclk  = 1'b0;
        gate_o.smclk = 1'b0;
      end
      PM_LP3: begin
        gate_o.cpu   = 1'b0;
        gate_o.mclk  = 1'b0;
        gate_o.smclk = 1'b0;
        gate_o.dcgen = 1'b0;
      end
      PM_LP4: begin
        gate_o = '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pmg_wake_seq.sv
module pmg_wake_seq
  import pmg_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  pmode_e req_mode_i,
  input  logic   req_wr_i,
  input  logic   irq_i,
  input  logic   reti_i,
  output pmode_e mode_o,
  output logic   svc_o,
  output logic   wake_o
);

  pmode_e mode_q, mode_d;
  pmode_e save_q, save_d;
  pmode_e save_src;
  logic   svc_q, svc_d;
  logic   wake_q, wake_d;
  logic   mode_en, save_en, svc_en;
  logic   start_svc, end_svc;

  // Next-state logic
  always_comb begin
    start_svc = !svc_q && irq_i;
    end_svc   = svc_q && reti_i;

    // A write in the wake cycle names the mode to come back to.
    save_src = req_wr_i ? req_mode_i : mode_q;
    save_en  = start_svc || (svc_q && req_wr_i);
    save_d   = svc_q ? req_mode_i : save_src;

    mode_en = start_svc || end_svc || (!svc_q && req_wr_i);
    if (start_svc)    mode_d = PM_ACTIVE;
    else if (end_svc) mode_d = req_wr_i ? req_mode_i : save_q;
    else              mode_d = req_mode_i;

    svc_en = start_svc || end_svc;
    svc_d  = start_svc;

    wake_d = start_svc && (mode_q != PM_ACTIVE);
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PM_ACTIVE;
      save_q <= PM_ACTIVE;
      svc_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (save_en) save_q <= save_d;
      if (svc_en)  svc_q  <= svc_d;
      wake_q <= wake_d;
    end
  end

  assign mode_o = mode_q;
  assign svc_o  = svc_q;
  assign wake_o = wake_q;

endmodule

// File: rtl/pmode_gate_ctrl.sv
module pmode_gate_ctrl
  import pmg_pkg::*;
#(
  parameter bit          DCO_MAIN_SRC = 1'b1,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_code_i,
  input  logic              mode_wr_i,
  input  logic              irq_pend_i,
  input  logic              reti_i,
  output logic              cpu_en_o,
  output logic              mclk_en_o,
  output logic              smclk_en_o,
  output logic              aclk_en_o,
  output logic              dcgen_en_o,
  output logic              xtal_en_o,
  output logic              wake_done_o
);

  logic   rst_sync_n;
  pmode_e req_mode;
  pmode_e cur_mode;
  gate_t  gates;
  logic   svc_q;

  pmg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pmg_mode_decode u_decode (
    .code_i (mode_code_i),
    .mode_o (req_mode)
  );

  pmg_wake_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .req_mode_i (req_mode),
    .req_wr_i   (mode_wr_i),
    .irq_i      (irq_pend_i),
    .reti_i     (reti_i),
    .mode_o     (cur_mode),
    .svc_o      (svc_q),
    .wake_o     (wake_done_o)
  );

  pmg_gate_map #(.DCO_MAIN_SRC(DCO_MAIN_SRC)) u_map (
    .mode_i (cur_mode),
    .gate_o (gates)
  );

  assign cpu_en_o   = gates.cpu;
  assign mclk_en_o  = gates.mclk;
  assign smclk_en_o = gates.smclk;
  assign aclk_en_o  = gates.aclk;
  assign dcgen_en_o = gates.dcgen;
  assign xtal_en_o  = gates.xtal;

endmodule

// File: rtl/pmg_checker.sv
module pmg_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic irq_i,
  input logic reti_i,
  input logic svc_i,
  input logic cpu_i,
  input logic mclk_i,
  input logic smclk_i,
  input logic aclk_i,
  input logic dcgen_i,
  input logic xtal_i,
  input logic wake_i
);

  AST_CPU_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_i |-> (mclk_i && smclk_i && aclk_i && dcgen_i && xtal_i)); // R2

  AST_MCLK_WITH_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mclk_i == cpu_i); // R3

  AST_SMCLK_KEEPS_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smclk_i && !cpu_i) |-> (aclk_i && xtal_i)); // R4

  AST_ACLK_OFF_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aclk_i |-> (!smclk_i && !dcgen_i && !xtal_i && !cpu_i)); // R7

  AST_IRQ_WAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_i && irq_i) |=> (cpu_i && wake_i)); // R10

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> !wake_i); // R10

  AST_RETURN_ENDS_SVC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && reti_i) |=> !svc_i); // R11

  AST_SVC_AWAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_i |-> cpu_i); // R12

  AST_RETI_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!svc_i && reti_i && !irq_i && !wr_i) |=>
      $stable({cpu_i, mclk_i, smclk_i, aclk_i, dcgen_i, xtal_i})); // R13

  AST_NO_WAKE_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_i && !svc_i && irq_i) |=> (cpu_i && !wake_i)); // R14

endmodule

bind pmode_gate_ctrl pmg_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (mode_wr_i),
  .irq_i   (irq_pend_i),
  .reti_i  (reti_i),
  .svc_i   (svc_q),
  .cpu_i   (cpu_en_o),
  .mclk_i  (mclk_en_o),
  .smclk_i (smclk_en_o),
  .aclk_i  (aclk_en_o),
  .dcgen_i (dcgen_en_o),
  .xtal_i  (xtal_en_o),
  .wake_i  (wake_done_o)
);

// File: tb/pmode_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module pmode_gate_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] code;
  logic       wr, irq, reti;
  logic       cpu, mclk, smclk, aclk, dcgen, xtal, wake;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // Reference model state
  int m_cur  = 0;
  int m_save = 0;
  bit m_svc  = 1'b0;
  bit m_wake = 1'b0;

  always #4 clk = ~clk;

  pmode_gate_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mode_code_i (code),
    .mode_wr_i   (wr),
    .irq_pend_i  (irq),
    .reti_i      (reti),
    .cpu_en_o    (cpu),
    .mclk_en_o   (mclk),
    .smclk_en_o  (smclk),
    .aclk_en_o   (aclk),
    .dcgen_en_o  (dcgen),
    .xtal_en_o   (xtal),
    .wake_done_o (wake)
  );

  // {cpu, mclk, smclk, aclk, dcgen, xtal}
  function automatic logic [5:0] exp_gates(int m);
    case (m)
      1:       return 6'b001111;
      2:       return 6'b001111;
      3:       return 6'b000111;
      4:       return 6'b000101;
      5:       return 6'b000000;
      default: return 6'b111111;
    endcase
  endfunction

  function automatic int dec(int c);
    return (c <= 5) ? c : 0;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string tag);
    logic [6:0] act, exp;
    act = {cpu, mclk, smclk, aclk, dcgen, xtal, wake};
    exp = {exp_gates(m_cur), m_wake};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model(bit w, int c, bit i, bit r);
    m_wake = 1'b0;
    if (!m_svc) begin
      if (i) begin
        m_save = w ? dec(c) : m_cur;
        m_wake = (m_cur != 0);
        m_cur  = 0;
        m_svc  = 1'b1;
      end else if (w) begin
        m_cur = dec(c);
      end
    end else begin
      if (w) m_save = dec(c);
      if (r) begin
        m_cur = m_save;
        m_svc = 1'b0;
      end
    end
  endtask

  task automatic drive(bit w, int c, bit i, bit r);
    wr   = w;
    code = 3'(c);
    irq  = i;
    reti = r;
  endtask

  task automatic step(bit w, int c, bit i, bit r, string tag);
    drive(w, c, i, r);
    @(negedge clk);
    model(w, c, i, r);
    check(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    drive(0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1"); // under reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1"); // after synchronous release

    // R13: return strobe outside service right after reset stays active
    step(0, 0, 0, 1, "R13");
    // R2..R8: every code, including undefined 6 and 7
    for (int c = 0; c < 8; c++) begin
      step(1, c, 0, 0, (c >= 6) ? "R8" : mode_tag(c));
    end
    // R9: latency, no same-cycle effect
    drive(1, 5, 0, 0);
    #1 check("R9");
    @(negedge clk);
    model(1, 5, 0, 0);
    check("R9");
    // R13 in LP4: return strobe outside service ignored
    step(0, 0, 0, 1, "R13");
    // R10: wake from LP4
    step(0, 0, 1, 0, "R10");
    step(0, 0, 0, 0, "R10");
    // R11: return restores LP4
    step(0, 0, 0, 1, "R11");
    // R12: in LP2, wake, then irq and write during service
    step(1, 3, 0, 0, "R5");
    step(0, 0, 1, 0, "R10");
    step(1, 1, 1, 0, "R12");
    step(0, 0, 1, 0, "R12");
    step(0, 0, 0, 1, "R11"); // resumes LP0 written during service
    // R11: write and return together
    step(0, 0, 1, 0, "R10");
    step(1, 4, 0, 1, "R11");
    // R14: interrupt while active
    step(1, 0, 0, 0, "R2");
    step(0, 0, 1, 0, "R14");
    step(0, 0, 0, 1, "R14");
    step(1, 3, 0, 0, "R5");
    // R10: wake with write in the wake cycle sets the resumed mode
    step(1, 2, 1, 0, "R10");
    step(0, 0, 0, 1, "R4");

    // Constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit w, i, r;
      int c;
      string tag;
      w = ($urandom_range(0, 99) < 20);
      i = ($urandom_range(0, 99) < 10);
      r = ($urandom_range(0, 99) < 20);
      c = $urandom_range(0, 7);
      drive(w, c, i, r);
      @(negedge clk);
      model(w, c, i, r);
      if (m_wake)     tag = "R10";
      else if (m_svc) tag = "R12";
      else            tag = mode_tag(m_cur);
      check(tag);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule